// File: doc/BRIEF.md
# Xoroshiro34+ Pseudo-Random Step Unit

This unit advances a 34-bit xoroshiro+ generator by one iteration each time `start` is asserted. The caller keeps 32 bits of the state in an ordinary data word and supplies it on `state_in`. The two remaining bits are carried as a pair of flag-like bits. Each bit is the least significant bit of one of the two 17-bit halves of the state. The upper half is `{state_in[31:16], carry bit}` and the lower half is `{state_in[15:0], zero bit}`.

One cycle after `start`, the unit presents four registered values with a single-cycle `valid` pulse:
- the new 32-bit word;
- the two new extra bits, on `c_out` and `z_out`;
- a 16-bit result, formed by adding the two new 16-bit halves and adding one more when both new extra bits are 1.

The `mode` input chooses the source of the extra bits:
- **mode 0** reads a private 2-bit shadow register, so a caller that keeps only the data word can still iterate.
- **mode 1** takes the extra bits from the `c_in`/`z_in` inputs, so any nonzero 34-bit state can be a seed. A mode 1 step also copies the new extra bits into the shadow register.

The shadow register resets to carry 0, zero 1. `force_seed` reloads those values, so an all-zero data word is still a legal seed.

Top module: `xoro34_step`

## Requirements
- R1: After synchronous reset, `valid` is 0, `state_out`, `c_out`, `z_out` and `rand_out` are 0, and the shadow pair holds carry 0, zero 1.
- R2: With upper word `s1 = {D[31:16], C}` and lower word `s0 = {D[15:0], Z}` (17 bits each), the unit computes `t = s1 ^ s0`, `s0' = rotl17(s0,7) ^ t ^ (t << 8)` and `s1' = rotl17(t,12)`. It returns `state_out = {s1'[16:1], s0'[16:1]}`, `c_out = s1'[0]` and `z_out = s0'[0]`.
- R3: `rand_out` equals `state_out[31:16] + state_out[15:0] + (c_out & z_out)`, modulo 2^16.
- R4: In mode 0 (`mode` = 0), C and Z are taken from the shadow pair, and a mode 0 step leaves the shadow pair unchanged.
- R5: In mode 1 (`mode` = 1), C and Z are taken from `c_in` and `z_in`, and the shadow pair loads the new `c_out`/`z_out` of that step.
- R6: `force_seed` sets the shadow pair to carry 0, zero 1 on the next edge. This overrides a mode 1 load in the same cycle. A mode 0 `start` in the same cycle still uses the shadow value held before the force.
- R7: Results appear on the edge after `start`, with `valid` high for exactly that cycle. Without `start`, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Perform one iteration this cycle |
| mode | input | 1 | 0: extra bits from shadow; 1: extra bits from c_in/z_in |
| force_seed | input | 1 | Reload shadow pair with carry 0, zero 1 |
| state_in | input | 32 | Current 32-bit data part of the state |
| c_in | input | 1 | External carry-side extra state bit (mode 1) |
| z_in | input | 1 | External zero-side extra state bit (mode 1) |
| valid | output | 1 | One-cycle pulse when results are new |
| state_out | output | 32 | Next 32-bit data part of the state |
| c_out | output | 1 | Next carry-side extra bit |
| z_out | output | 1 | Next zero-side extra bit |
| rand_out | output | 16 | Pseudo-random 16-bit result |

## Verification
The bench chains more than ten thousand steps, mixing the two modes, fed-back and fresh seeds, and forced reseeds. Every step is compared against a bench model of the 17-bit rotate/shift update.

Several corner cases get directed checks:
- **Overflow increment.** The rounds where both new extra bits are 1 are checked, because a design that dropped the increment would be off by one exactly there.
- **All-zero data word in mode 0.** This must still produce a nonzero state, since the shadow supplies zero = 1. A design with a wrong shadow reset value would return all zeros.
- **Shadow write rules.** A mode 1 step followed by a mode 0 step exposes whether the shadow was loaded. A force in the same cycle as a mode 1 step exposes the priority between the two.
- **Idle cycles.** These expose outputs that drift or a `valid` that lingers.

// File: rtl/xoro34_pkg.sv
package xoro34_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = HALF_W + 1;
  localparam int DATA_W = 2 * HALF_W;
  localparam int ROT_A  = 7;
  localparam int SHF_B  = 8;
  localparam int ROT_C  = 12;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t hi;
    word_t lo;
  } xstate_t;
endpackage

// File: rtl/xoro34_core.sv
module xoro34_core
  import xoro34_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int RA = ROT_A,
  parameter int SB = SHF_B,
  parameter int RC = ROT_C
) (
  input  logic [W-1:0] s_hi,
  input  logic [W-1:0] s_lo,
  output logic [W-1:0] n_hi,
  output logic [W-1:0] n_lo
);
  logic [W-1:0] mix;
  logic [W-1:0] lo_rot;
  logic [W-1:0] mix_shl;
  logic [W-1:0] mix_rot;

  assign mix     = s_hi ^ s_lo;
  assign lo_rot  = {s_lo[W-1-RA:0], s_lo[W-1:W-RA]};
  assign mix_shl = {mix[W-1-SB:0], {SB{1'b0}}};
  assign mix_rot = {mix[W-1-RC:0], mix[W-1:W-RC]};
  assign n_lo    = lo_rot ^ mix ^ mix_shl;
  assign n_hi    = mix_rot;
endmodule

// File: rtl/xoro34_sum.sv
module xoro34_sum #(
  parameter int HW = 16
) (
  input  logic [HW-1:0] a,
  input  logic [HW-1:0] b,
  input  logic          inc,
  output logic [HW-1:0] sum
);
  assign sum = a + b + {{(HW-1){1'b0}}, inc};
endmodule

// File: rtl/xoro34_shadow.sv
module xoro34_shadow #(
  parameter logic INIT_C = 1'b0,
  parameter logic INIT_Z = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic force_seed,
  input  logic load,
  input  logic ld_c,
  input  logic ld_z,
  output logic sh_c,
  output logic sh_z
);
  always_ff @(posedge clk) begin
    if (rst || force_seed) begin
      sh_c <= INIT_C;
      sh_z <= INIT_Z;
    end else if (load) begin
      sh_c <= ld_c;
      sh_z <= ld_z;
    end
  end
endmodule

// File: rtl/xoro34_step.sv
module xoro34_step
  import xoro34_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter int RA = ROT_A,
  parameter int SB = SHF_B,
  parameter int RC = ROT_C,
  localparam int W  = HW + 1,
  localparam int DW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode,
  input  logic          force_seed,
  input  logic [DW-1:0] state_in,
  input  logic          c_in,
  input  logic          z_in,
  output logic          valid,
  output logic [DW-1:0] state_out,
  output logic          c_out,
  output logic          z_out,
  output logic [HW-1:0] rand_out
);
  logic          sh_c, sh_z;
  logic          use_c, use_z;
  logic [W-1:0]  cur_hi, cur_lo, nxt_hi, nxt_lo;
  logic [HW-1:0] nxt_sum;

  assign use_c  = mode ? c_in : sh_c;
  assign use_z  = mode ? z_in : sh_z;
  assign cur_hi = {state_in[DW-1:HW], use_c};
  assign cur_lo = {state_in[HW-1:0], use_z};

  xoro34_core #(.W(W), .RA(RA), .SB(SB), .RC(RC)) u_core (
    .s_hi(cur_hi), .s_lo(cur_lo), .n_hi(nxt_hi), .n_lo(nxt_lo)
  );

  xoro34_sum #(.HW(HW)) u_sum (
    .a(nxt_hi[W-1:1]), .b(nxt_lo[W-1:1]),
    .inc(nxt_hi[0] & nxt_lo[0]), .sum(nxt_sum)
  );

  xoro34_shadow u_shadow (
    .clk(clk), .rst(rst), .force_seed(force_seed),
    .load(start & mode), .ld_c(nxt_hi[0]), .ld_z(nxt_lo[0]),
    .sh_c(sh_c), .sh_z(sh_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      state_out <= '0;
      c_out     <= 1'b0;
      z_out     <= 1'b0;
      rand_out  <= '0;
    end else begin
      valid <= start;
      if (start) begin
        state_out <= {nxt_hi[W-1:1], nxt_lo[W-1:1]};
        c_out     <= nxt_hi[0];
        z_out     <= nxt_lo[0];
        rand_out  <= nxt_sum;
      end
    end
  end
endmodule

// File: rtl/xoro34_step_chk.sv
module xoro34_step_chk #(
  parameter int HW = 16,
  localparam int DW = 2 * HW
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          mode,
  input logic          force_seed,
  input logic          valid,
  input logic [DW-1:0] state_out,
  input logic          c_out,
  input logic          z_out,
  input logic [HW-1:0] rand_out,
  input logic          sh_c,
  input logic          sh_z
);
  // R7
  valid_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> valid);
  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!valid && $stable(state_out) && $stable(rand_out) && $stable(c_out) && $stable(z_out)));
  // R3
  sum_relation_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (rand_out == HW'(state_out[DW-1:HW] + state_out[HW-1:0] + {{(HW-1){1'b0}}, c_out & z_out})));
  // R6
  force_reload_chk: assert property (@(posedge clk) disable iff (rst)
    force_seed |=> (!sh_c && sh_z));
  // R4
  shadow_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!force_seed && !(start && mode)) |=> ($stable(sh_c) && $stable(sh_z)));
  // R5
  shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start && mode && !force_seed) |=> (sh_c == c_out && sh_z == z_out));
endmodule

bind xoro34_step xoro34_step_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .force_seed(force_seed),
  .valid(valid), .state_out(state_out), .c_out(c_out), .z_out(z_out),
  .rand_out(rand_out), .sh_c(sh_c), .sh_z(sh_z)
);

// File: tb/xoro34_step_test.sv
module xoro34_step_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, mode = 1'b0, force_seed = 1'b0;
  logic [31:0] state_in = '0;
  logic        c_in = 1'b0, z_in = 1'b0;
  logic        valid, c_out, z_out;
  logic [31:0] state_out;
  logic [15:0] rand_out;

  int errors = 0;
  int checks = 0;
  logic m_sc = 1'b0, m_sz = 1'b1;

  always #5 clk = ~clk;

  xoro34_step uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .force_seed(force_seed),
    .state_in(state_in), .c_in(c_in), .z_in(z_in), .valid(valid),
    .state_out(state_out), .c_out(c_out), .z_out(z_out), .rand_out(rand_out)
  );

  function automatic logic [16:0] rotl17(input logic [16:0] x, input int k);
    return 17'((x << k) | (x >> (17 - k)));
  endfunction

  // returns {state[31:0], c, z, rand[15:0]}
  function automatic logic [49:0] model(input logic [31:0] d, input logic c, input logic z);
    logic [16:0] s1, s0, t, n0, n1;
    logic [15:0] r;
    s1 = {d[31:16], c};
    s0 = {d[15:0], z};
    t  = s1 ^ s0;
    n0 = rotl17(s0, 7) ^ t ^ 17'(t << 8);
    n1 = rotl17(t, 12);
    r  = n1[16:1] + n0[16:1] + {15'd0, n1[0] & n0[0]};
    return {n1[16:1], n0[16:1], n1[0], n0[0], r};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one step, check results one cycle later
  task automatic step(input logic [31:0] d, input logic md, input logic ci, input logic zi,
                      input logic frc, input string req);
    logic [49:0] e;
    logic uc, uz;
    uc = md ? ci : m_sc;
    uz = md ? zi : m_sz;
    e  = model(d, uc, uz);
    @(negedge clk);
    state_in = d; mode = md; c_in = ci; z_in = zi; start = 1'b1; force_seed = frc;
    @(negedge clk);
    start = 1'b0; force_seed = 1'b0;
    if (frc) begin m_sc = 1'b0; m_sz = 1'b1; end
    else if (md) begin m_sc = e[17]; m_sz = e[16]; end
    chk(valid == 1'b1, {req, " R7 valid"}, 64'(valid), 64'd1);
    chk({state_out, c_out, z_out} == e[49:16], {req, " R2 state"},
        64'({state_out, c_out, z_out}), 64'(e[49:16]));
    chk(rand_out == e[15:0], {req, " R3 rand"}, 64'(rand_out), 64'(e[15:0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] hold_r;
    logic [31:0] hold_s;
    int incs;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(valid == 1'b0 && state_out == 0 && rand_out == 0 && !c_out && !z_out,
        "R1 reset outputs", 64'({valid, state_out, rand_out}), 64'd0);
    // R1 R4: zero data word with reset shadow (c=0,z=1) must be nonzero
    step(32'h0, 1'b0, 1'b1, 1'b1, 1'b0, "R1 R4 zero seed");
    chk({state_out, c_out, z_out} != 34'd0, "R4 nonzero from zero word", 64'(state_out), 64'd1);
    // R4: mode 0 ignores c_in/z_in and does not change shadow
    step(32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b0, "R4 mode0 a");
    step(32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, "R4 mode0 b");
    // R5: mode 1 load, then mode 0 must use loaded bits
    step(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1, 1'b0, "R5 mode1 load");
    step(32'hCAFE_0001, 1'b0, 1'b0, 1'b0, 1'b0, "R5 mode0 after load");
    // R6: force together with mode 1 step: force wins
    step(32'h0F0F_F0F0, 1'b1, 1'b0, 1'b1, 1'b1, "R6 force vs load");
    step(32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R6 after force");
    // R6: mode0 start same cycle as force uses old shadow
    step(32'hAAAA_5555, 1'b1, 1'b1, 1'b0, 1'b0, "R6 prep");
    step(32'h5555_AAAA, 1'b0, 1'b0, 1'b0, 1'b1, "R6 start with force");
    step(32'h7777_1111, 1'b0, 1'b0, 1'b0, 1'b0, "R6 post force");
    // R7: idle cycles hold outputs, valid low
    hold_r = rand_out; hold_s = state_out;
    repeat (3) @(negedge clk);
    chk(!valid && rand_out == hold_r && state_out == hold_s, "R7 hold",
        64'({valid, rand_out}), 64'({1'b0, hold_r}));

    // random chain
    void'($urandom(32'd4242));
    d = 32'h0000_0001;
    incs = 0;
    for (int i = 0; i < 10000; i++) begin
      logic md, frc, ci, zi;
      md  = ($urandom % 4) != 0;
      frc = ($urandom % 50) == 0;
      ci  = c_out; zi = z_out;
      if (($urandom % 100) == 0) begin
        d = $urandom; ci = $urandom; zi = $urandom;
      end
      step(d, md, ci, zi, frc, "R2 R3 chain");
      if (c_out && z_out) begin
        incs++;
        // R3 overflow increment case
        chk(rand_out == 16'(state_out[31:16] + state_out[15:0] + 16'd1), "R3 increment",
            64'(rand_out), 64'(16'(state_out[31:16] + state_out[15:0] + 16'd1)));
      end
      d = state_out;
      if (($urandom % 20) == 0) @(negedge clk);
    end
    chk(incs > 0, "R3 increment seen", 64'(incs), 64'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule